// File: doc/BRIEF.md
# SPI Register Access Port

This block lets an external SPI master read and write a bank of up to 32 byte-wide registers. SCLK, MOSI and the active-low select are brought into the system clock domain through a two-flop synchroniser, and SCLK edges are detected there. All decoding and shifting runs on the system clock. Each transaction opens with a command byte. Its upper five bits name a register, one bit selects write or read, and its lowest bit asks the USB logic behind the bank to finish the status stage of the current control transfer. While that command byte shifts in, MISO returns a live snapshot of eight status bits.

After the command, the master can clock any number of data bytes until it raises select. The address stays fixed across the burst, so a register that fronts a FIFO can be filled or drained with one command. Each written byte gives one write pulse. Each read byte gives one read pulse once it has been shifted out. The register side therefore sees `reg_rd` as a "byte consumed" strobe and shows the next value on `reg_rdata`. The port samples MOSI on rising SCLK edges and updates MISO after falling edges, so SPI modes (0,0) and (1,1) both work without a mode input.

Top module: `spi_regport`

## Requirements
- R1: A transaction begins when `ss_n` goes low and ends when it goes high. Once `ss_n` has been high for 4 system clocks, `miso` is 0. Write and read pulses appear only after the command byte of a transaction has completed.
- R2: In the command byte, bits 7:3 are the register address, which is driven on `reg_addr`. Bit 1 = 1 makes each following byte a write (`reg_wr` with that byte on `reg_wdata`). Bit 1 = 0 makes the transaction a read.
- R3: When bit 0 of the command byte is 1, `ack_stb` pulses high for exactly one system clock after that byte completes. When bit 0 is 0, `ack_stb` does not pulse.
- R4: During the command byte, MISO carries the value `status_i` had when select fell, most significant bit first.
- R5: Mode (0,0), with SCLK idle low, and mode (1,1), with SCLK idle high, give identical results. Both sample on the rising edge.
- R6: In a burst the address does not change. Each written data byte gives exactly one `reg_wr` pulse. Each read data byte gives exactly one `reg_rd` pulse after it completes, and `reg_rdata` is then expected to show the next value.
- R7: Bytes are transferred MSB first in both directions.
- R8: For a read, `reg_rdata` is captured two system clocks after the command byte (or a `reg_rd` pulse), and that value is shifted out as the next data byte.
- R9: Bit 2 of the command byte has no effect.
- R10: If select rises partway through a byte, the partial bits are discarded. The next transaction starts with a fresh command byte.
- R11: `reg_wr`, `reg_rd` and `ack_stb` are single-cycle pulses, and `reg_wr` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 12 times the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low select |
| miso | output | 1 | Serial data to the master; 0 when idle |
| status_i | input | 8 | Status bits returned during the command byte |
| reg_addr | output | 5 | Register address latched from the command |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle read-consumed strobe |
| reg_rdata | input | 8 | Read data from the selected register |
| ack_stb | output | 1 | One-cycle status-stage acknowledge strobe |

## Verification
The bench runs the same write and read-back in both SPI modes, using different status snapshots. A design that shifted on the idle-high first edge in mode (1,1) would return a status byte rotated by one bit. Burst reads and writes to a FIFO-like register check that each byte gives exactly one strobe and that order is kept. An extra prefetch pulse, or a moved address, would lose or repeat a FIFO entry. An aborted half-byte comes before a normal write, so a bit counter that is not cleared on select would misdecode the next command and raise a stray acknowledge. Commands with bit 2 set and with the acknowledge bit set confirm that only bit 0 produces a strobe.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int DIR_BIT = 1;   // 1 = write
    localparam int ACK_BIT = 0;   // status-stage acknowledge
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              active;
        logic              cmd_phase;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shin;
        logic [DATA_W-1:0] shout;
        logic              arm;
        logic [1:0]        ld;
        logic [ADDR_W-1:0] addr;
        logic              wr_mode;
        logic              wr_p;
        logic              rd_p;
        logic              ack_p;
        logic [DATA_W-1:0] wdata;
    } core_st_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    assign prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/spi_regport_core.sv
module spi_regport_core
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              miso_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rd_o,
    output logic              ack_o
);
    core_st_t q, n;
    logic [DATA_W-1:0] byte_v;

    always_comb begin
        n        = q;
        n.wr_p   = 1'b0;
        n.rd_p   = 1'b0;
        n.ack_p  = 1'b0;
        n.active = active_i;
        byte_v   = {q.shin[DATA_W-2:0], mosi_i};
        if (!active_i) begin
            // idle: clear framing, track the live status for the next command
            n.bitcnt    = '0;
            n.cmd_phase = 1'b1;
            n.arm       = 1'b0;
            n.ld        = 2'd0;
            n.shin      = '0;
            n.shout     = status_i;
        end else begin
            if (q.ld == 2'd2) begin
                n.ld = 2'd1;
            end else if (q.ld == 2'd1) begin
                n.shout = rdata_i;
                n.ld    = 2'd0;
            end
            if (rise_i) begin
                n.shin = byte_v;
                if (q.bitcnt == LAST_BIT) begin
                    n.bitcnt = '0;
                    n.arm    = 1'b0;
                    if (q.cmd_phase) begin
                        n.cmd_phase = 1'b0;
                        n.addr      = byte_v[DATA_W-1 -: ADDR_W];
                        n.wr_mode   = byte_v[DIR_BIT];
                        n.ack_p     = byte_v[ACK_BIT];
                        if (byte_v[DIR_BIT]) n.shout = '0;
                        else                 n.ld    = 2'd2;
                    end else if (q.wr_mode) begin
                        n.wr_p  = 1'b1;
                        n.wdata = byte_v;
                        n.shout = '0;
                    end else begin
                        n.rd_p = 1'b1;
                        n.ld   = 2'd2;
                    end
                end else begin
                    n.bitcnt = q.bitcnt + 1'b1;
                    n.arm    = 1'b1;
                end
            end else if (fall_i && q.arm) begin
                n.shout = {q.shout[DATA_W-2:0], 1'b0};
                n.arm   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.cmd_phase <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign miso_o  = q.active & q.shout[DATA_W-1];
    assign addr_o  = q.addr;
    assign wr_o    = q.wr_p;
    assign wdata_o = q.wdata;
    assign rd_o    = q.rd_p;
    assign ack_o   = q.ack_p;

    assert_wr_rd_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wr_p && q.rd_p));
    assert_wr_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_p |-> q.wr_mode);
    assert_rd_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_p |-> !q.wr_mode);
    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack_p |=> !q.ack_p);
    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (q.bitcnt == '0 && q.cmd_phase));
    assert_data_after_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr_p || q.rd_p) |-> !q.cmd_phase);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              ss_n,
    output logic              miso,
    input  logic [DATA_W-1:0] status_i,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ack_stb
);
    logic [2:0] pins_s;
    logic [0:0] sclk_rise, sclk_fall;

    spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n, mosi, sclk}), .q(pins_s));

    spi_regport_edge #(.W(1), .RST_VAL(1'b0)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pins_s[0]),
        .rise(sclk_rise), .fall(sclk_fall));

    spi_regport_core u_core (
        .clk(clk), .rst_n(rst_n),
        .active_i(~pins_s[2]), .rise_i(sclk_rise[0]), .fall_i(sclk_fall[0]),
        .mosi_i(pins_s[1]), .status_i(status_i), .rdata_i(reg_rdata),
        .miso_o(miso), .addr_o(reg_addr), .wr_o(reg_wr), .wdata_o(reg_wdata),
        .rd_o(reg_rd), .ack_o(ack_stb));

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_idle_miso_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[2] && $past(pins_s[2])) |-> !miso);
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
    localparam int HP = 8;
    localparam logic [4:0] FA = 5'd20;

    logic clk = 0, rst_n = 0;
    logic sclk = 0, mosi = 0, ss_n = 1;
    logic miso, reg_wr, reg_rd, ack_stb;
    logic [7:0] status_i = 8'h00, reg_wdata, reg_rdata;
    logic [4:0] reg_addr;

    always #5 clk = ~clk;

    spi_regport uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .miso(miso), .status_i(status_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .ack_stb(ack_stb));

    // behavioural register bank with one FIFO-style address
    logic [7:0] bank [32];
    logic [7:0] fmem [16];
    int fwp = 0, frp = 0;
    int wr_n = 0, rd_n = 0, ack_n = 0;
    int checks = 0, errors = 0, idle_cnt = 0;
    bit done = 0;
    logic [7:0] tx [8];
    logic [7:0] rx [8];

    initial for (int i = 0; i < 32; i++) bank[i] = 8'h00;
    assign reg_rdata = (reg_addr == FA) ? fmem[frp[3:0]] : bank[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_n <= wr_n + 1;
            if (reg_addr == FA) begin fmem[fwp[3:0]] <= reg_wdata; fwp <= fwp + 1; end
            else bank[reg_addr] <= reg_wdata;
        end
        if (reg_rd) begin
            rd_n <= rd_n + 1;
            if (reg_addr == FA) frp <= frp + 1;
        end
        if (ack_stb) ack_n <= ack_n + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock reference: idle line level and pulse exclusivity
    logic prev_ack = 0;
    always @(negedge clk) if (rst_n && !done) begin
        idle_cnt = ss_n ? idle_cnt + 1 : 0;
        if (idle_cnt >= 4) check("R1 idle miso", miso, 0);
        check("R11 wr/rd exclusive", reg_wr & reg_rd, 0);
        check("R11 ack single", prev_ack & ack_stb, 0);
        prev_ack = ack_stb;
    end

    task automatic xfer(input bit cpol, input int nb);
        sclk = cpol;
        repeat (4) @(negedge clk);
        ss_n = 0;
        repeat (HP) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            for (int i = 7; i >= 0; i--) begin
                sclk = 0;
                mosi = tx[b][i];
                repeat (HP) @(negedge clk);
                rx[b][i] = miso;
                sclk = 1;
                repeat (HP) @(negedge clk);
            end
        end
        if (!cpol) sclk = 0;
        repeat (HP) @(negedge clk);
        ss_n = 1;
        repeat (12) @(negedge clk);
        sclk = cpol;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0, r0, a0;
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check("R1 reset miso", miso, 0);
        check("R11 reset strobes", {reg_wr, reg_rd, ack_stb}, 0);

        // R2 R4 R7: write reg 3, mode (0,0)
        status_i = 8'h5C; w0 = wr_n; a0 = ack_n;
        tx[0] = 8'h1A; tx[1] = 8'hA5; xfer(0, 2);
        check("R4 status byte", rx[0], 8'h5C);
        check("R2 write reg3", bank[3], 8'hA5);
        check("R6 one write pulse", wr_n - w0, 1);
        check("R3 no ack", ack_n - a0, 0);

        // R8 R7: read reg 3
        r0 = rd_n;
        tx[0] = 8'h18; tx[1] = 8'h00; xfer(0, 2);
        check("R8 read reg3", rx[1], 8'hA5);
        check("R6 one read pulse", rd_n - r0, 1);

        // R5: mode (1,1)
        status_i = 8'hC3;
        tx[0] = 8'h4A; tx[1] = 8'h3C; xfer(1, 2);
        check("R5 mode11 status", rx[0], 8'hC3);
        check("R5 mode11 write", bank[9], 8'h3C);
        tx[0] = 8'h48; tx[1] = 8'h00; xfer(1, 2);
        check("R5 mode11 read", rx[1], 8'h3C);

        // R6: burst write then burst read on FIFO address
        w0 = wr_n;
        tx[0] = 8'hA2; tx[1] = 8'h11; tx[2] = 8'h22; tx[3] = 8'h33; xfer(0, 4);
        check("R6 burst writes", wr_n - w0, 3);
        check("R6 fifo fill", fwp - frp, 3);
        r0 = rd_n;
        tx[0] = 8'hA0; tx[1] = 0; tx[2] = 0; tx[3] = 0; xfer(0, 4);
        check("R6 burst rd0", rx[1], 8'h11);
        check("R6 burst rd1", rx[2], 8'h22);
        check("R6 burst rd2", rx[3], 8'h33);
        check("R6 burst read pulses", rd_n - r0, 3);

        // R3: acknowledge bit
        a0 = ack_n;
        tx[0] = 8'h19; tx[1] = 8'h00; xfer(0, 2);
        check("R3 ack pulse", ack_n - a0, 1);
        check("R3 read with ack", rx[1], 8'hA5);

        // R9: bit 2 ignored
        tx[0] = 8'h26; tx[1] = 8'h77; xfer(0, 2);
        check("R9 write bit2", bank[4], 8'h77);
        tx[0] = 8'h24; tx[1] = 8'h00; xfer(1, 2);
        check("R9 read bit2", rx[1], 8'h77);

        // R10: partial byte then a clean write
        w0 = wr_n; a0 = ack_n;
        sclk = 0; ss_n = 0; repeat (HP) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            mosi = 1; repeat (HP) @(negedge clk);
            sclk = 1; repeat (HP) @(negedge clk);
            sclk = 0;
        end
        repeat (HP) @(negedge clk);
        ss_n = 1; repeat (12) @(negedge clk);
        tx[0] = 8'h32; tx[1] = 8'h5A; xfer(0, 2);
        check("R10 write after abort", bank[6], 8'h5A);
        check("R10 single write", wr_n - w0, 1);
        check("R10 no stray ack", ack_n - a0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule